// File: doc/BRIEF.md
# GPIO pin interrupt detector

This block watches a bank of general-purpose input pins and turns pin activity into interrupt requests. Each pin has its own configuration byte and its own sticky status bit. The pin inputs are first brought into the clock domain through a two-stage synchroniser. A per-pin detector then looks for either an active level or an edge, as the configuration selects, and latches any hit into the status bit. Software clears the status bit by writing a zero to it.

Latching and signalling are controlled separately. A raw-status enable decides whether events are recorded at all. It is part of the detect input path, so turning it on while a pin is high looks like a rising edge. An interrupt enable only decides whether a recorded status is forwarded. A three-bit target field steers each pin's request to one of eight processor interrupt lines, and each line is the OR of all requests routed to it. Line 4 is the application processor.

A parameter picks between two detector variants. The wide variant has a two-bit mode field. The narrow variant has a one-bit edge/level field, and in edge mode the polarity bit selects the edge.

Top module: `gpio_irq_detect`

## Requirements
- R1: After reset every configuration byte, every status bit and every interrupt output line reads zero.
- R2: An input change is recorded in the status bit on the third rising clock edge after it is applied: two synchroniser stages and then the status register.
- R3: In the wide variant the mode field is config bits [4:3]. Code 0 is level, 1 is rising edge, 2 is falling edge and 3 is both edges. In the edge codes the polarity bit (config bit 2) has no effect.
- R4: In level mode a polarity of 1 makes a high input active and a polarity of 0 makes a low input active. While the active level persists, the status bit is set again in the same cycle that a clear is written, so it reads 1 after the clear.
- R5: The status bit is sticky. Writing a byte with bit 0 = 0 to a pin's status address clears it. Writing bit 0 = 1 leaves it unchanged.
- R6: A clear written in the same cycle that a new event is detected leaves the status bit set.
- R7: The interrupt enable (config bit 0) gates only the request toward the output line. Status still latches while it is 0, and setting it afterwards raises the line at once.
- R8: With raw-status enable (config bit 1) at 0, no event latches. Setting it while the input is high records a rising edge in the rising and both-edge modes, one cycle after the write takes effect.
- R9: Output line t is the OR, over all pins whose target field (config bits [7:5]) equals t, of status AND interrupt enable. Target 4 is the application processor line.
- R10: In the narrow variant config bit 3 selects edge (1) or level (0), and config bit 4 is ignored. In edge mode polarity 1 detects rising and polarity 0 detects falling edges. Changing the polarity re-arms detection for the opposite edge at once.
- R11: Register address bit 0 selects configuration (0) or status (1), and the upper address bits select the pin. Reads are combinational: a configuration read returns the stored byte, and a status read returns the status in bit 0 with the other bits zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_in | input | NUM_PINS | Asynchronous pin inputs |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | $clog2(NUM_PINS)+1 | Register address: {pin index, config/status select} |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Combinational read data at reg_addr |
| irq_out | output | 8 | One interrupt request line per target processor |

## Verification
The assertions assume that the pin inputs stay at a constant value during reset, so that the synchroniser stages agree from the first active edge, and that the register address always names an existing pin. The bench meets both conditions. It holds every pin low through reset and addresses only the four pins that exist. It changes pins only at falling clock edges and holds each value for at least three cycles before sampling, so every transition passes the synchroniser whole. The sweeps cover all mode, polarity and old/new input combinations on one pin, and directed cases cover the collision, gating, raw-enable and routing corners.

// File: rtl/gpio_irq_pkg.sv
`timescale 1ns/1ps
package gpio_irq_pkg;
    localparam int CFG_W  = 8;
    localparam int TGT_W  = 3;
    localparam int NUM_TGT = 1 << TGT_W;

    localparam logic [1:0] MODE_LEVEL = 2'd0;
    localparam logic [1:0] MODE_RISE  = 2'd1;
    localparam logic [1:0] MODE_FALL  = 2'd2;
    localparam logic [1:0] MODE_BOTH  = 2'd3;

    typedef struct packed {
        logic [TGT_W-1:0] target;
        logic [1:0]       mode;
        logic             pol;
        logic             raw_en;
        logic             irq_en;
    } pin_cfg_t;
endpackage

// File: rtl/gpio_sync.sv
`timescale 1ns/1ps
module gpio_sync #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    typedef struct packed {
        logic [W-1:0] m1;
        logic [W-1:0] m2;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d.m1 = d;
        s_d.m2 = s_q.m1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign q = s_q.m2;

    // R2
    sync_stage_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.m2 == $past(s_q.m1));
endmodule

// File: rtl/gpio_pin_detect.sv
`timescale 1ns/1ps
module gpio_pin_detect
    import gpio_irq_pkg::*;
#(
    parameter int DET_WIDTH = 2
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     smp,
    input  logic     cfg_we,
    input  pin_cfg_t cfg_wdata,
    input  logic     clr_we,
    input  logic     clr_bit,
    output pin_cfg_t cfg_o,
    output logic     status_o
);
    typedef struct packed {
        pin_cfg_t cfg;
        logic     status;
        logic     prev;
    } pin_state_t;

    pin_state_t st_d, st_q;
    logic gated, rise, fall, active, evt, lvl_sel;

    always_comb begin
        gated  = st_q.cfg.raw_en & smp;
        rise   = gated & ~st_q.prev;
        fall   = ~gated & st_q.prev;
        active = st_q.cfg.pol ? smp : ~smp;
    end

    generate
        if (DET_WIDTH == 2) begin : g_wide
            always_comb begin
                lvl_sel = (st_q.cfg.mode == MODE_LEVEL);
                case (st_q.cfg.mode)
                    MODE_LEVEL: evt = active;
                    MODE_RISE:  evt = rise;
                    MODE_FALL:  evt = fall;
                    default:    evt = rise | fall;
                endcase
            end
        end else begin : g_narrow
            always_comb begin
                lvl_sel = ~st_q.cfg.mode[0];
                if (st_q.cfg.mode[0]) evt = st_q.cfg.pol ? rise : fall;
                else                  evt = active;
            end
        end
    endgenerate

    always_comb begin
        st_d        = st_q;
        st_d.prev   = gated;
        if (cfg_we) st_d.cfg = cfg_wdata;
        st_d.status = (st_q.cfg.raw_en & evt) | (st_q.status & ~(clr_we & ~clr_bit));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cfg_o    = st_q.cfg;
    assign status_o = st_q.status;

    // R8
    raw_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.status) |-> $past(st_q.cfg.raw_en));
    // R5
    clear_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st_q.status) |-> $past(clr_we && !clr_bit));
    // R4
    level_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cfg.raw_en && lvl_sel && active) |=> st_q.status);
endmodule

// File: rtl/gpio_irq_route.sv
`timescale 1ns/1ps
module gpio_irq_route #(
    parameter int NUM_PINS = 4,
    parameter int TGT_W    = 3,
    parameter int NUM_TGT  = 8
) (
    input  logic [NUM_PINS-1:0]       req,
    input  logic [NUM_PINS*TGT_W-1:0] tgt_flat,
    output logic [NUM_TGT-1:0]        irq
);
    generate
        for (genvar t = 0; t < NUM_TGT; t++) begin : g_tgt
            logic [NUM_PINS-1:0] match;
            for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
                assign match[p] = req[p] && (tgt_flat[p*TGT_W +: TGT_W] == TGT_W'(t));
            end
            assign irq[t] = |match;
        end
    endgenerate
endmodule

// File: rtl/gpio_irq_detect.sv
`timescale 1ns/1ps
module gpio_irq_detect
    import gpio_irq_pkg::*;
#(
    parameter int NUM_PINS  = 4,
    parameter int DET_WIDTH = 2,
    localparam int PIN_W    = $clog2(NUM_PINS),
    localparam int ADDR_W   = PIN_W + 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] pin_in,
    input  logic                reg_we,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic [CFG_W-1:0]    reg_wdata,
    output logic [CFG_W-1:0]    reg_rdata,
    output logic [NUM_TGT-1:0]  irq_out
);
    logic [NUM_PINS-1:0]       smp;
    logic [NUM_PINS-1:0]       stat_vec;
    logic [NUM_PINS-1:0]       en_vec;
    logic [NUM_PINS*TGT_W-1:0] tgt_flat;
    pin_cfg_t                  cfg_arr [NUM_PINS];
    logic [PIN_W-1:0]          pin_sel;
    logic                      sel_stat;

    assign pin_sel  = reg_addr[ADDR_W-1:1];
    assign sel_stat = reg_addr[0];

    gpio_sync #(.W(NUM_PINS)) sync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pin_in),
        .q     (smp)
    );

    generate
        for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
            logic hit_pin;
            assign hit_pin = reg_we && (pin_sel == PIN_W'(i));
            gpio_pin_detect #(.DET_WIDTH(DET_WIDTH)) det_i (
                .clk       (clk),
                .rst_n     (rst_n),
                .smp       (smp[i]),
                .cfg_we    (hit_pin && !sel_stat),
                .cfg_wdata (pin_cfg_t'(reg_wdata)),
                .clr_we    (hit_pin && sel_stat),
                .clr_bit   (reg_wdata[0]),
                .cfg_o     (cfg_arr[i]),
                .status_o  (stat_vec[i])
            );
            assign en_vec[i] = cfg_arr[i].irq_en;
            assign tgt_flat[i*TGT_W +: TGT_W] = cfg_arr[i].target;
        end
    endgenerate

    gpio_irq_route #(.NUM_PINS(NUM_PINS), .TGT_W(TGT_W), .NUM_TGT(NUM_TGT)) route_i (
        .req      (stat_vec & en_vec),
        .tgt_flat (tgt_flat),
        .irq      (irq_out)
    );

    always_comb begin
        if (sel_stat) reg_rdata = {{(CFG_W-1){1'b0}}, stat_vec[pin_sel]};
        else          reg_rdata = cfg_arr[pin_sel];
    end

    // R9
    route_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (~|(stat_vec & en_vec)) |-> (irq_out == '0));
    // R7
    route_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(irq_out) <= $countones(stat_vec & en_vec));
endmodule

// File: tb/gpio_irq_detect_tb.sv
`timescale 1ns/1ps
module gpio_irq_detect_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] pin_a = '0, pin_b = '0;
    logic       we_a = 1'b0, we_b = 1'b0;
    logic [2:0] addr_a = '0, addr_b = '0;
    logic [7:0] wd_a = '0, wd_b = '0;
    logic [7:0] rdata_a, rdata_b;
    logic [7:0] irq_a, irq_b;
    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    gpio_irq_detect #(.NUM_PINS(4), .DET_WIDTH(2)) dut_i (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_a), .reg_we(we_a),
        .reg_addr(addr_a), .reg_wdata(wd_a), .reg_rdata(rdata_a), .irq_out(irq_a));

    gpio_irq_detect #(.NUM_PINS(4), .DET_WIDTH(1)) dut_nar_i (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_b), .reg_we(we_b),
        .reg_addr(addr_b), .reg_wdata(wd_b), .reg_rdata(rdata_b), .irq_out(irq_b));

    function automatic logic [7:0] mk(input int tgt, input int mode, input int pol,
                                      input int raw, input int en);
        return {3'(tgt), 2'(mode), 1'(pol), 1'(raw), 1'(en)};
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input bit nar, input int a, input logic [7:0] d);
        if (nar) begin we_b = 1'b1; addr_b = 3'(a); wd_b = d; end
        else     begin we_a = 1'b1; addr_a = 3'(a); wd_a = d; end
        @(negedge clk);
        we_a = 1'b0; we_b = 1'b0;
    endtask

    task automatic rd(input bit nar, input int a, output logic [7:0] v);
        if (nar) addr_b = 3'(a); else addr_a = 3'(a);
        #1;
        v = nar ? rdata_b : rdata_a;
    endtask

    task automatic st(input bit nar, input int pin, output int v);
        logic [7:0] r;
        rd(nar, pin*2+1, r);
        v = int'(r);
    endtask

    task automatic reset_all();
        for (int p = 0; p < 4; p++) begin wr(0, p*2, 8'h00); wr(1, p*2, 8'h00); end
        pin_a = '0; pin_b = '0;
        tick(4);
        for (int p = 0; p < 4; p++) begin wr(0, p*2+1, 8'h00); wr(1, p*2+1, 8'h00); end
    endtask

    function automatic int exp_evt(input int mode, input int pol, input int o, input int n);
        case (mode)
            0: return (pol != 0 ? o : 1 - o) | (pol != 0 ? n : 1 - n);
            1: return (o == 0 && n == 1) ? 1 : 0;
            2: return (o == 1 && n == 0) ? 1 : 0;
            default: return (o != n) ? 1 : 0;
        endcase
    endfunction

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : main
        logic [7:0] r;
        int s;
        tick(3);
        rst_n = 1'b1;
        tick(1);

        // R1 / R11: reset state through every address
        for (int a = 0; a < 8; a++) begin
            rd(0, a, r);
            chk("R1 reset register read", int'(r), 0);
        end
        chk("R1 reset irq lines", int'(irq_a), 0);

        // R11: configuration readback and status layout
        wr(0, 4, 8'hA5);
        rd(0, 4, r);
        chk("R11 config readback", int'(r), 8'hA5);
        rd(0, 5, r);
        chk("R11 status read upper bits zero", int'(r), 0);
        reset_all();

        // R2: latency of three edges
        wr(0, 0, mk(4, 1, 1, 1, 1));
        pin_a[0] = 1'b1;
        tick(2);
        st(0, 0, s); chk("R2 not yet after two edges", s, 0);
        tick(1);
        st(0, 0, s); chk("R2 latched after three edges", s, 1);
        reset_all();

        // R3 / R4: sweep of mode, polarity and transition on pin 0
        for (int m = 0; m < 4; m++) begin
            for (int p = 0; p < 2; p++) begin
                for (int o = 0; o < 2; o++) begin
                    for (int n = 0; n < 2; n++) begin
                        int e;
                        wr(0, 0, mk(4, m, p, 1, 1));
                        pin_a[0] = 1'(o);
                        tick(4);
                        wr(0, 1, 8'h00);
                        pin_a[0] = 1'(n);
                        tick(3);
                        e = exp_evt(m, p, o, n);
                        st(0, 0, s);
                        chk($sformatf("R3 mode=%0d pol=%0d %0d->%0d status", m, p, o, n), s, e);
                        chk($sformatf("R9 mode=%0d pol=%0d %0d->%0d line4", m, p, o, n),
                            int'(irq_a), e << 4);
                        if (m == 0) begin
                            wr(0, 1, 8'h00);
                            st(0, 0, s);
                            chk($sformatf("R4 level pol=%0d in=%0d after clear", p, n), s,
                                (p != 0) ? n : 1 - n);
                        end
                    end
                end
            end
        end
        reset_all();

        // R6 / R5: clear colliding with an event, then write-1 and plain clear
        wr(0, 4, mk(4, 1, 1, 1, 1));
        pin_a[2] = 1'b1;
        tick(2);
        wr(0, 5, 8'h00);
        st(0, 2, s); chk("R6 clear with same-cycle event keeps status", s, 1);
        wr(0, 5, 8'h01);
        st(0, 2, s); chk("R5 writing one keeps status", s, 1);
        wr(0, 5, 8'h00);
        st(0, 2, s); chk("R5 writing zero clears status", s, 0);
        chk("R5 line drops after clear", int'(irq_a), 0);
        reset_all();

        // R7: enable gates only the request
        wr(0, 4, mk(4, 1, 1, 1, 0));
        pin_a[2] = 1'b1;
        tick(3);
        st(0, 2, s); chk("R7 status latches while disabled", s, 1);
        chk("R7 line quiet while disabled", int'(irq_a), 0);
        wr(0, 4, mk(4, 1, 1, 1, 1));
        chk("R7 line rises on enable", int'(irq_a), 8'h10);
        reset_all();

        // R8: raw-status enable
        wr(0, 2, mk(4, 1, 1, 0, 1));
        pin_a[1] = 1'b1;
        tick(4);
        st(0, 1, s); chk("R8 no latch with raw disabled", s, 0);
        wr(0, 2, mk(4, 1, 1, 1, 1));
        tick(1);
        st(0, 1, s); chk("R8 enabling raw while high records edge", s, 1);
        reset_all();

        // R9: routing over several pins
        wr(0, 0, mk(2, 0, 1, 1, 1));
        wr(0, 2, mk(5, 0, 1, 1, 1));
        wr(0, 6, mk(5, 0, 1, 1, 1));
        pin_a = 4'b1011;
        tick(3);
        chk("R9 lines 2 and 5", int'(irq_a), (1 << 2) | (1 << 5));
        wr(0, 2, mk(5, 0, 1, 1, 0));
        chk("R9 line 5 held by pin 3", int'(irq_a), (1 << 2) | (1 << 5));
        wr(0, 6, mk(5, 0, 1, 1, 0));
        chk("R9 line 5 drops", int'(irq_a), 1 << 2);
        reset_all();

        // R10: narrow variant
        wr(1, 0, mk(4, 1, 1, 1, 1));
        pin_b[0] = 1'b1; tick(3);
        st(1, 0, s); chk("R10 narrow rising with pol 1", s, 1);
        chk("R10 narrow line4", int'(irq_b), 8'h10);
        wr(1, 1, 8'h00);
        pin_b[0] = 1'b0; tick(3);
        st(1, 0, s); chk("R10 narrow falling ignored with pol 1", s, 0);
        wr(1, 0, mk(4, 1, 0, 1, 1));
        pin_b[0] = 1'b1; tick(3);
        st(1, 0, s); chk("R10 narrow rising ignored with pol 0", s, 0);
        pin_b[0] = 1'b0; tick(3);
        st(1, 0, s); chk("R10 narrow re-armed for falling", s, 1);
        wr(1, 1, 8'h00);
        wr(1, 0, mk(4, 2, 1, 1, 1));
        pin_b[0] = 1'b1; tick(3);
        st(1, 0, s); chk("R10 narrow level with bit4 ignored", s, 1);
        wr(1, 1, 8'h00);
        st(1, 0, s); chk("R10 narrow level persists after clear", s, 1);
        pin_b[0] = 1'b0; tick(3);
        wr(1, 1, 8'h00);
        st(1, 0, s); chk("R10 narrow level inactive clears", s, 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule